// File: doc/BRIEF.md
# Daisy-Chain Enumeration Sequencer

This block runs the discovery step of a chain of stacked monitor devices after power-up or reset. When started, it puts every device into a known state and locks the addressing. It then asks the whole chain to return its low control register, and reads the returned words one at a time until the chain runs out. The result is the highest device index in the chain (the device count minus one). It is reported with a one-cycle completion pulse and a two-bit status code.

The sequencer does not serialise frames itself. It places each command on a frame-builder interface as a register address, a data byte, a target device address and a broadcast flag, and waits for that interface to accept the command. It requests response words from a frame receiver and judges each word itself. Each word must carry a correct 8-bit CRC. Its 5-bit device address field, which arrives least-significant bit first, must match the position of the word in the chain.

Top module: `chain_probe_seq`

## Requirements
- R1: After synchronous reset, `done`, `err`, `top_idx`, `tx_valid` and `rx_req` are all zero.
- R2: A `start` pulse makes the block issue three commands in order. All three are broadcast (`tx_bcast`=1) to device address 0. (1) Register 0x0E with data bit 7 (reset) =1, bit 4 (must-be-one) =1, bit 2 (address lock) =1, bit 0 (chain readback) =1, bits 6:5 = `ACQ_CODE`, bit 3 = `THERM_EN`; with default parameters this is 0x95. (2) The same write with bit 7 clear (default 0x15). (3) Register 0x1C with data 0x38, which is 0x0E shifted left by two.
- R3: A command stays on the builder interface, with `tx_valid` high and its address and data unchanged, until a cycle with `tx_ready` high. Only that handshake moves the block to the next command.
- R4: After the third command, `rx_req` is high and each `rx_valid` cycle delivers word number n, counting from 0. The word is good when both of these hold. First, bits 9:2 equal the CRC, computed as ((D[21:8]·x^8) mod P) xor D[7:0], where D = word bits 31:10 and P = x^8+x^5+x^3+x^2+x+1. Second, bits 31:27 read in reverse order (bit 27 as the MSB) equal n.
- R5: An all-zero word at index n ≥ 1 ends the scan with `done` high, `err`=2'b00 and `top_idx`=n−1.
- R6: An all-zero word at index 0, meaning the chain returned nothing, ends the scan with `err`=2'b01 and `top_idx`=0.
- R7: A nonzero word that fails the CRC or address test ends the scan with `err`=2'b01 and `top_idx`=0.
- R8: A good nonzero word at index `MAX_DEV` (the ninth word, by default) ends the scan with `err`=2'b10 (chain too long) and `top_idx`=0.
- R9: `done` is high for exactly one cycle per completed scan. `err` and `top_idx` change only in that cycle and hold until the next completion.
- R10: `start` in any state abandons the current scan without a `done` pulse and restarts from command (1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart enumeration |
| tx_valid | output | 1 | Command present for the frame builder |
| tx_dev | output | 5 | Target device address of the command |
| tx_reg | output | 6 | Register address of the command |
| tx_data | output | 8 | Data byte of the command |
| tx_bcast | output | 1 | Command goes to all devices |
| tx_ready | input | 1 | Frame builder accepts the command this cycle |
| rx_req | output | 1 | Sequencer wants a response word |
| rx_valid | input | 1 | Response word present this cycle |
| rx_word | input | 32 | Response word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 00 ok, 01 bad word or empty chain, 10 chain too long |
| top_idx | output | 3 | Highest device index found |

## Verification
The assertions check on every cycle that a pending command holds still until it is accepted, and that the mandatory bits are set in every low-control write. They also check that commands and word requests never overlap, that `done` is a single-cycle pulse, that `err` and `top_idx` move only with it, and that a rejected word or a zero word ends the scan on the next cycle. Whether the CRC and bit-reversed address decoding actually accept correct chains, and whether the reported index matches the chain length, can only be shown by the bench's scenarios. These cover chains of one to eight devices, a nine-deep chain, corrupted words and a restart in mid-scan.

// File: rtl/chain_probe_pkg.sv
package chain_probe_pkg;

    localparam int ADDR_W = 5;
    localparam int REG_W  = 6;
    localparam int DATA_W = 8;
    localparam int WORD_W = 32;
    localparam int CRC_W  = 8;

    localparam logic [REG_W-1:0]  REG_CTRL_LO = 6'h0E;
    localparam logic [REG_W-1:0]  REG_RD_SEL  = 6'h1C;
    localparam logic [ADDR_W-1:0] DEV_MASTER  = 5'h00;

    // bit positions inside the low control byte
    localparam int CL_SWRST = 7;
    localparam int CL_ACQ   = 5;
    localparam int CL_MUST  = 4;
    localparam int CL_THERM = 3;
    localparam int CL_LOCK  = 2;
    localparam int CL_RDBK  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_RST,
        ST_WR_RUN,
        ST_WR_SEL,
        ST_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        PRB_OK      = 2'b00,
        PRB_BADWORD = 2'b01,
        PRB_TOOLONG = 2'b10
    } probe_err_e;

    typedef struct packed {
        logic              valid;
        logic [REG_W-1:0]  reg_a;
        logic [DATA_W-1:0] data;
    } tx_cmd_t;

    // remainder of (d[21:8] * x^8) mod (x^8+x^5+x^3+x^2+x+1), folded with d[7:0]
    function automatic logic [CRC_W-1:0] crc8_of(input logic [21:0] d);
        logic [21:0] r;
        r = {d[21:8], 8'h00};
        for (int i = 21; i >= 8; i--) begin
            if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h12F;
        end
        return r[7:0] ^ d[7:0];
    endfunction

    function automatic logic [ADDR_W-1:0] rev_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] o;
        for (int i = 0; i < ADDR_W; i++) o[i] = a[ADDR_W-1-i];
        return o;
    endfunction

endpackage

// File: rtl/probe_cmd_mux.sv
module probe_cmd_mux
    import chain_probe_pkg::*;
#(
    parameter logic [1:0] ACQ_CODE = 2'd0,
    parameter bit         THERM_EN = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state,
    output tx_cmd_t    cmd
);
    localparam logic [DATA_W-1:0] CTRL_RUN =
        (DATA_W'(1) << CL_MUST) | (DATA_W'(1) << CL_LOCK) | (DATA_W'(1) << CL_RDBK) |
        (DATA_W'(ACQ_CODE) << CL_ACQ) | (DATA_W'(THERM_EN) << CL_THERM);
    localparam logic [DATA_W-1:0] CTRL_RST = CTRL_RUN | (DATA_W'(1) << CL_SWRST);
    localparam logic [DATA_W-1:0] SEL_DATA = DATA_W'(REG_CTRL_LO) << 2;

    always_comb begin
        cmd = '0;
        unique case (state)
            ST_WR_RST: cmd = '{valid: 1'b1, reg_a: REG_CTRL_LO, data: CTRL_RST};
            ST_WR_RUN: cmd = '{valid: 1'b1, reg_a: REG_CTRL_LO, data: CTRL_RUN};
            ST_WR_SEL: cmd = '{valid: 1'b1, reg_a: REG_RD_SEL,  data: SEL_DATA};
            default:   cmd = '0;
        endcase
    end

    AST_CTRL_MANDATORY: assert property (@(posedge clk) disable iff (rst)
        (cmd.valid && cmd.reg_a == REG_CTRL_LO) |-> (cmd.data[CL_MUST] && cmd.data[CL_LOCK] && cmd.data[CL_RDBK])); // R2

endmodule

// File: rtl/probe_word_check.sv
module probe_word_check
    import chain_probe_pkg::*;
#(
    parameter int MAX_DEV = 8,
    localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  idx,
    output logic              is_zero,
    output logic              good
);
    logic [CRC_W-1:0]  crc_calc;
    logic [ADDR_W-1:0] addr_seen;
    logic              crc_ok;
    logic              addr_ok;

    always_comb begin
        is_zero   = (word == '0);
        crc_calc  = crc8_of(word[31:10]);
        crc_ok    = (crc_calc == word[9:2]);
        addr_seen = rev_addr(word[31:27]);
        addr_ok   = (addr_seen == ADDR_W'(idx));
        good      = crc_ok && addr_ok;
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx <= CNT_W'(MAX_DEV)); // R8

endmodule

// File: rtl/chain_probe_seq.sv
module chain_probe_seq
    import chain_probe_pkg::*;
#(
    parameter int         MAX_DEV  = 8,
    parameter logic [1:0] ACQ_CODE = 2'd0,
    parameter bit         THERM_EN = 1'b0,
    localparam int        CNT_W    = $clog2(MAX_DEV + 1),
    localparam int        IDX_W    = $clog2(MAX_DEV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              tx_valid,
    output logic [4:0]        tx_dev,
    output logic [5:0]        tx_reg,
    output logic [7:0]        tx_data,
    output logic              tx_bcast,
    input  logic              tx_ready,
    output logic              rx_req,
    input  logic              rx_valid,
    input  logic [31:0]       rx_word,
    output logic              done,
    output logic [1:0]        err,
    output logic [IDX_W-1:0]  top_idx
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    tx_cmd_t          cmd;
    logic             w_zero;
    logic             w_good;
    logic             w_take;

    probe_cmd_mux #(.ACQ_CODE(ACQ_CODE), .THERM_EN(THERM_EN)) cmd_i (
        .clk(clk), .rst(rst), .state(state), .cmd(cmd)
    );

    probe_word_check #(.MAX_DEV(MAX_DEV)) chk_i (
        .clk(clk), .rst(rst), .word(rx_word), .idx(cnt),
        .is_zero(w_zero), .good(w_good)
    );

    assign tx_valid = cmd.valid;
    assign tx_reg   = cmd.reg_a;
    assign tx_data  = cmd.data;
    assign tx_dev   = DEV_MASTER;
    assign tx_bcast = 1'b1;
    assign rx_req   = (state == ST_READ);
    assign w_take   = rx_req && rx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            done    <= 1'b0;
            err     <= PRB_OK;
            top_idx <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state <= ST_WR_RST;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_WR_RST: if (tx_ready) state <= ST_WR_RUN;
                    ST_WR_RUN: if (tx_ready) state <= ST_WR_SEL;
                    ST_WR_SEL: if (tx_ready) state <= ST_READ;
                    ST_READ: begin
                        if (w_take) begin
                            if (w_zero) begin
                                done    <= 1'b1;
                                state   <= ST_IDLE;
                                if (cnt == '0) begin
                                    err     <= PRB_BADWORD;
                                    top_idx <= '0;
                                end else begin
                                    err     <= PRB_OK;
                                    top_idx <= IDX_W'(cnt - 1'b1);
                                end
                            end else if (!w_good) begin
                                done    <= 1'b1;
                                state   <= ST_IDLE;
                                err     <= PRB_BADWORD;
                                top_idx <= '0;
                            end else if (cnt == CNT_W'(MAX_DEV)) begin
                                done    <= 1'b1;
                                state   <= ST_IDLE;
                                err     <= PRB_TOOLONG;
                                top_idx <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !start) |=> (tx_valid && $stable(tx_reg) && $stable(tx_data))); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_req)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(err) && $stable(top_idx))); // R9

    AST_ZERO_ENDS: assert property (@(posedge clk) disable iff (rst)
        (w_take && !start && rx_word == '0) |=> done); // R5

    AST_BAD_WORD: assert property (@(posedge clk) disable iff (rst)
        (w_take && !start && rx_word != '0 && !w_good) |=> (done && err == 2'b01)); // R7

    AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
        start |=> !done); // R10

endmodule

// File: tb/chain_probe_seq_tb_top.sv
module chain_probe_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        tx_valid, tx_bcast, tx_ready = 1'b0;
    logic [4:0]  tx_dev;
    logic [5:0]  tx_reg;
    logic [7:0]  tx_data;
    logic        rx_req, rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        done;
    logic [1:0]  err;
    logic [2:0]  top_idx;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    chain_probe_seq dut_i (
        .clk(clk), .rst(rst), .start(start),
        .tx_valid(tx_valid), .tx_dev(tx_dev), .tx_reg(tx_reg), .tx_data(tx_data),
        .tx_bcast(tx_bcast), .tx_ready(tx_ready),
        .rx_req(rx_req), .rx_valid(rx_valid), .rx_word(rx_word),
        .done(done), .err(err), .top_idx(top_idx)
    );

    // kind: 0 clean, 1 bad CRC, 2 bad address
    typedef struct packed {
        logic [3:0] ndev;
        logic [3:0] bad_at;
        logic [1:0] kind;
        logic [1:0] gap;
        logic [1:0] exp_err;
        logic [2:0] exp_idx;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 4'd0, 2'd0, 2'd0, 2'b00, 3'd0},  // R5 single device
        '{4'd3, 4'd0, 2'd0, 2'd1, 2'b00, 3'd2},  // R5
        '{4'd8, 4'd0, 2'd0, 2'd2, 2'b00, 3'd7},  // R5 longest legal chain
        '{4'd9, 4'd0, 2'd0, 2'd0, 2'b10, 3'd0},  // R8 no terminator
        '{4'd4, 4'd2, 2'd1, 2'd1, 2'b01, 3'd0},  // R7 CRC fault
        '{4'd5, 4'd0, 2'd2, 2'd0, 2'b01, 3'd0},  // R7 address fault
        '{4'd0, 4'd0, 2'd0, 2'd2, 2'b01, 3'd0},  // R6 empty chain
        '{4'd9, 4'd8, 2'd1, 2'd0, 2'b01, 3'd0},  // R7 ninth word corrupted
        '{4'd6, 4'd0, 2'd0, 2'd3, 2'b00, 3'd5}   // R5 slow builder
    };

    function automatic logic [7:0] tab_ent(input logic [7:0] x);
        logic [7:0] c;
        logic       hb;
        c = x;
        for (int i = 0; i < 8; i++) begin
            hb = c[7];
            c  = c << 1;
            if (hb) c = c ^ 8'h2F;
        end
        return c;
    endfunction

    function automatic logic [7:0] ref_crc(input logic [21:0] d);
        logic [7:0] c;
        c = tab_ent({2'b00, d[21:16]});
        c = tab_ent(c ^ d[15:8]);
        return c ^ d[7:0];
    endfunction

    function automatic logic [4:0] flip5(input logic [4:0] a);
        logic [4:0] o;
        for (int i = 0; i < 5; i++) o[4-i] = a[i];
        return o;
    endfunction

    function automatic logic [31:0] mk_word(input int n, input bit bad_crc, input bit bad_addr);
        logic [21:0] d;
        logic [7:0]  c;
        logic [31:0] w;
        d = {flip5(bad_addr ? 5'(n + 1) : 5'(n)), 17'h0A5A5 ^ 17'(n * 3)};
        c = ref_crc(d);
        w = {d, c, 2'b10};
        if (bad_crc) w[2] = ~w[2];
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic do_cmd(input logic [5:0] er, input logic [7:0] ed, input int gap);
        while (!tx_valid) @(negedge clk);
        chk(tx_reg == er, "R2 reg", tx_reg, er);
        chk(tx_data == ed, "R2 data", tx_data, ed);
        chk(tx_bcast && tx_dev == 5'd0, "R2 bcast/dev", {tx_bcast, tx_dev}, 6'h20);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(tx_valid && tx_reg == er && tx_data == ed, "R3 hold", tx_data, ed);
        end
        tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        while (!rx_req) @(negedge clk);
        rx_valid = 1'b1;
        rx_word  = w;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_word  = '0;
    endtask

    task automatic do_cmds(input int gap);
        do_cmd(6'h0E, 8'h95, gap);
        do_cmd(6'h0E, 8'h15, gap);
        do_cmd(6'h1C, 8'h38, gap);
    endtask

    task automatic run_vec(input vec_t v);
        logic [31:0] w;
        bit          cb, ab, term;
        pulse_start();
        do_cmds(int'(v.gap));
        chk(rx_req, "R4 rx_req after cmds", rx_req, 1);
        for (int n = 0; n <= 8; n++) begin
            cb = (v.kind == 2'd1) && (n == int'(v.bad_at));
            ab = (v.kind == 2'd2) && (n == int'(v.bad_at));
            w  = (n < int'(v.ndev)) ? mk_word(n, cb, ab) : 32'h0;
            term = (w == 32'h0) || cb || ab || (n == 8);
            send_word(w);
            if (term) begin
                chk(done, "R9 done pulse", done, 1);
                chk(err == v.exp_err, "R5-R8 err", err, v.exp_err);
                chk(top_idx == v.exp_idx, "R5 top_idx", top_idx, v.exp_idx);
                @(negedge clk);
                chk(!done, "R9 single cycle", done, 0);
                chk(err == v.exp_err && top_idx == v.exp_idx, "R9 result hold", {err, top_idx}, {v.exp_err, v.exp_idx});
                break;
            end else begin
                chk(!done && rx_req, "R4 word accepted", {done, rx_req}, 2'b01);
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && err == 2'b00 && top_idx == 3'd0 && !tx_valid && !rx_req,
            "R1 reset state", {done, err, top_idx, tx_valid, rx_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !rx_req, "R1 idle after reset", {tx_valid, rx_req}, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10: restart in the middle of the readback, then a clean run
        pulse_start();
        do_cmds(0);
        send_word(mk_word(0, 1'b0, 1'b0));
        send_word(mk_word(1, 1'b0, 1'b0));
        chk(!done && err == 2'b00 && top_idx == 3'd5, "R10 no result mid-scan", {done, err, top_idx}, 5);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && tx_valid && tx_data == 8'h95, "R10 restart at reset write", tx_data, 8'h95);
        chk(err == 2'b00 && top_idx == 3'd5, "R10 result kept on abort", {err, top_idx}, 5);
        run_vec('{4'd2, 4'd0, 2'd0, 2'd1, 2'b00, 3'd1});

        // R10: restart while a command waits for the builder
        pulse_start();
        repeat (2) @(negedge clk);
        chk(tx_valid && tx_data == 8'h95, "R3 waits for ready", tx_data, 8'h95);
        run_vec('{4'd7, 4'd0, 2'd0, 2'd0, 2'b00, 3'd6});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule